// File: doc/BRIEF.md
# Protected Byte Update Controller

This block decides how one byte of a byte-addressed nonvolatile array is changed, and it times that change. Each byte has a companion lock bit, and a lock bit can only go from clear to set. A request carries an address, a new byte, a flag asking for the lock bit to be set, and a flag that selects match mode. The block compares the new byte with the stored byte. It then runs an erase phase, a write phase, both, or neither. Each phase lasts a fixed number of clock cycles. When the phase sequence ends, the block commits the result to its register-modelled arrays.

Here "erase" drives bits from 0 to 1 and leaves the byte at FFh, and "write" drives bits from 1 to 0. An outside security unit reports whether a valid code check has happened, through `auth_ok`. Without it every request is refused. A second, independent read port shows any byte and its lock bit at all times.

The state machine has three states. `ST_IDLE` accepts requests. It goes to `ST_ERASE` when some bit must rise, to `ST_WRITE` when only falls are needed or a match-mode lock is granted, and stays in `ST_IDLE` for a refusal or a no-change request. `ST_ERASE` moves to `ST_WRITE` when its budget expires and a write must follow, and otherwise returns to `ST_IDLE`. `ST_WRITE` returns to `ST_IDLE` when its budget expires.

Top module: `pbu_ctrl`

## Requirements
- R1: After reset, busy, done, rej, erase_on and write_on are low, every byte reads FFh and every lock bit reads 0.
- R2: A request accepted while auth_ok is low gives a one-cycle rej in the next cycle. Busy never rises and the array is unchanged.
- R3: A data-change request (req_cmp=0) to a byte whose lock bit is 1 is refused with rej, and the byte keeps its value.
- R4: An erase phase is needed when some bit goes 0→1. A write phase is needed when the new byte has a 0 where the byte left after the erase phase (FFh if an erase runs, else the old byte) has a 1. After a completed update the byte equals the new byte.
- R5: When both phases are needed, busy is high for 203 cycles. erase_on is high for the first 100 and write_on for the next 103. The byte reads FFh during the write phase.
- R6: When exactly one phase is needed, busy is high for 103 cycles and only the matching phase output is high.
- R7: A request that needs no phase finishes at once: done is high in the cycle after acceptance and busy never rises. If req_lock=1, the lock bit is set at that point.
- R8: In match mode (req_cmp=1) with auth_ok high, an unlocked byte equal to req_data gets a 103-cycle write phase and then its lock bit is set, with the data unchanged. A mismatch gives rej. An already locked byte finishes at once with done.
- R9: A lock bit never returns to 0. An update with req_lock=1 sets the lock bit at completion together with the data.
- R10: Requests presented while busy, including in the last busy cycle, are ignored. done is high for the one cycle after the last busy cycle, and a request presented in that done cycle is accepted.
- R11: done and rej are never high together, and erase_on and write_on are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one budget pulse |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_addr | input | 10 | Byte address |
| req_data | input | 8 | New byte, or match byte in match mode |
| req_lock | input | 1 | Also set the lock bit of this byte |
| req_cmp | input | 1 | Match mode: lock only if the byte equals req_data |
| auth_ok | input | 1 | Security check has succeeded |
| rd_addr | input | 10 | Read-port address |
| rd_data | output | 8 | Byte at rd_addr |
| rd_lock | output | 1 | Lock bit at rd_addr |
| busy | output | 1 | A phase sequence is running |
| done | output | 1 | One-cycle completion pulse |
| rej | output | 1 | One-cycle refusal pulse |
| erase_on | output | 1 | Erase phase active |
| write_on | output | 1 | Write phase active |

## Verification
Two functions can meet in the same cycle: the end of one phase sequence and the arrival of the next request. The bench presents one request in the final busy cycle, which must be dropped. It presents another in the cycle where done is high, which must start a new sequence. The scoreboard judges both cases from the busy length and phase split of each completion in order. Port reads afterwards show that the dropped address is still FFh and the accepted one holds its new value.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_WRITE = 2'd2
    } pbu_state_e;
endpackage

// File: rtl/pbu_diff.sv
module pbu_diff #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] nxt,
    output logic              need_erase,
    output logic              need_write
);
    logic [DATA_W-1:0] after_erase;

    always_comb begin
        need_erase  = |(~cur & nxt);
        after_erase = need_erase ? {DATA_W{1'b1}} : cur;
        need_write  = |(after_erase & ~nxt);
    end
endmodule

// File: rtl/pbu_timer.sv
module pbu_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (cnt == '0)); // R5
endmodule

// File: rtl/pbu_store.sv
module pbu_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    output logic [DATA_W-1:0] a_data,
    output logic              a_lock,
    input  logic              we,
    input  logic              lock_set,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_data,
    output logic              b_lock
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  lock_bits;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
            lock_bits <= '0;
        end else begin
            if (we) begin
                mem[wa] <= wd;
            end
            if (lock_set) begin
                lock_bits[wa] <= 1'b1;
            end
        end
    end

    assign a_data = mem[a_addr];
    assign a_lock = lock_bits[a_addr];
    assign b_data = mem[b_addr];
    assign b_lock = lock_bits[b_addr];

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(b_addr) && $past(b_lock)) |-> b_lock); // R9
endmodule

// File: rtl/pbu_ctrl.sv
module pbu_ctrl
    import pbu_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int BOTH_PULSES = 203,
    parameter int ONE_PULSES  = 103
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_lock,
    input  logic              req_cmp,
    input  logic              auth_ok,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_lock,
    output logic              busy,
    output logic              done,
    output logic              rej,
    output logic              erase_on,
    output logic              write_on
);
    localparam int CNT_W = $clog2(BOTH_PULSES + 1);
    localparam logic [CNT_W-1:0] ONE_LD  = CNT_W'(ONE_PULSES - 1);
    localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(BOTH_PULSES - ONE_PULSES - 1);

    pbu_state_e        state, state_n;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              lat_lock, lat_cmp, lat_nw;

    logic [DATA_W-1:0] cur_data;
    logic              cur_lock;
    logic              need_e, need_w;
    logic              t_load, t_last;
    logic [CNT_W-1:0]  t_val;
    logic              mem_we, mem_lock;
    logic [ADDR_W-1:0] mem_wa;
    logic [DATA_W-1:0] mem_wd;
    logic              fin, refuse;

    pbu_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_addr(req_addr), .a_data(cur_data), .a_lock(cur_lock),
        .we(mem_we), .lock_set(mem_lock), .wa(mem_wa), .wd(mem_wd),
        .b_addr(rd_addr), .b_data(rd_data), .b_lock(rd_lock)
    );

    pbu_diff #(.DATA_W(DATA_W)) u_diff (
        .cur(cur_data), .nxt(req_data),
        .need_erase(need_e), .need_write(need_w)
    );

    pbu_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(t_load), .load_val(t_val), .last(t_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_addr <= '0;
            lat_data <= '0;
            lat_lock <= 1'b0;
            lat_cmp  <= 1'b0;
            lat_nw   <= 1'b0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && req_valid) begin
                lat_addr <= req_addr;
                lat_data <= req_data;
                lat_lock <= req_lock;
                lat_cmp  <= req_cmp;
                lat_nw   <= need_w;
            end
        end
    end

    // next state and array commit
    always_comb begin
        state_n  = state;
        t_load   = 1'b0;
        t_val    = '0;
        mem_we   = 1'b0;
        mem_lock = 1'b0;
        mem_wa   = lat_addr;
        mem_wd   = lat_data;
        fin      = 1'b0;
        refuse   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                mem_wa = req_addr;
                mem_wd = req_data;
                if (req_valid) begin
                    if (!auth_ok) begin
                        refuse = 1'b1;
                    end else if (req_cmp) begin
                        if (cur_lock) begin
                            fin = 1'b1;
                        end else if (cur_data == req_data) begin
                            state_n = ST_WRITE;
                            t_load  = 1'b1;
                            t_val   = ONE_LD;
                        end else begin
                            refuse = 1'b1;
                        end
                    end else if (cur_lock) begin
                        refuse = 1'b1;
                    end else if (need_e) begin
                        state_n = ST_ERASE;
                        t_load  = 1'b1;
                        t_val   = need_w ? LEAD_LD : ONE_LD;
                    end else if (need_w) begin
                        state_n = ST_WRITE;
                        t_load  = 1'b1;
                        t_val   = ONE_LD;
                    end else begin
                        fin      = 1'b1;
                        mem_lock = req_lock;
                    end
                end
            end
            ST_ERASE: begin
                if (t_last) begin
                    mem_we = 1'b1;
                    if (lat_nw) begin
                        state_n = ST_WRITE;
                        t_load  = 1'b1;
                        t_val   = ONE_LD;
                        mem_wd  = '1;
                    end else begin
                        state_n  = ST_IDLE;
                        mem_lock = lat_lock;
                        fin      = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                if (t_last) begin
                    state_n  = ST_IDLE;
                    mem_we   = !lat_cmp;
                    mem_lock = lat_lock | lat_cmp;
                    fin      = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            rej  <= 1'b0;
        end else begin
            done <= fin;
            rej  <= refuse;
        end
    end

    assign busy     = (state != ST_IDLE);
    assign erase_on = (state == ST_ERASE);
    assign write_on = (state == ST_WRITE);

    AST_NO_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !auth_ok) |=> (!busy && !done && rej)); // R2
    AST_DONE_REJ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && rej)); // R11
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_on && write_on)); // R11
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !t_last) |=> busy); // R10
    AST_ERASE_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(erase_on) && !done) |-> write_on); // R5
    AST_LOCKED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_cmp && cur_lock) |=> (rej && !busy)); // R3
endmodule

// File: tb/test_pbu_ctrl.sv
`timescale 1ns/1ps
module test_pbu_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       req_lock = 1'b0;
    logic       req_cmp = 1'b0;
    logic       auth_ok = 1'b0;
    logic [9:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rd_lock, busy, done, rej, erase_on, write_on;

    always #2.5 clk = ~clk;

    pbu_ctrl i_pbu_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_lock(req_lock), .req_cmp(req_cmp),
        .auth_ok(auth_ok), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_lock(rd_lock), .busy(busy), .done(done), .rej(rej),
        .erase_on(erase_on), .write_on(write_on)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string q_tag[$];
    int    q_kind[$], q_busy[$], q_er[$], q_wr[$];
    int    run_b = 0, run_e = 0, run_w = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind: 0 = done, 1 = rej
    task automatic expect_item(input string tag, input int kind, input int b, input int e, input int w);
        q_tag.push_back(tag);
        q_kind.push_back(kind);
        q_busy.push_back(b);
        q_er.push_back(e);
        q_wr.push_back(w);
    endtask

    task automatic fire(input logic [9:0] a, input logic [7:0] d, input logic lk,
                        input logic cm, input logic au);
        req_addr  = a;
        req_data  = d;
        req_lock  = lk;
        req_cmp   = cm;
        auth_ok   = au;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (q_tag.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic readchk(input string tag, input logic [9:0] a, input logic [7:0] ed, input logic el);
        rd_addr = a;
        #1;
        chk(rd_data == ed, {tag, " data"}, rd_data, ed);
        chk(rd_lock == el, {tag, " lock"}, rd_lock, el);
    endtask

    task automatic run(input string tag, input logic [9:0] a, input logic [7:0] d, input logic lk,
                       input logic cm, input logic au, input int kind, input int b,
                       input int e, input int w);
        expect_item(tag, kind, b, e, w);
        fire(a, d, lk, cm, au);
        wait_idle();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) run_b++;
            if (erase_on) run_e++;
            if (write_on) run_w++;
            if (done || rej) begin
                chk(!(done && rej), "R11 done and rej together", {done, rej}, 2);
                if (q_tag.size() == 0) begin
                    chk(1'b0, "R10 unexpected completion", {done, rej}, 0);
                end else begin
                    string t;
                    int k, b, e, w;
                    t = q_tag.pop_front();
                    k = q_kind.pop_front();
                    b = q_busy.pop_front();
                    e = q_er.pop_front();
                    w = q_wr.pop_front();
                    chk(int'(rej) == k, {t, " kind"}, rej, k);
                    chk(run_b == b, {t, " busy cycles"}, run_b, b);
                    chk(run_e == e && run_w == w, {t, " phase split"}, run_e * 1000 + run_w, e * 1000 + w);
                end
                run_b = 0;
                run_e = 0;
                run_w = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, rej, erase_on, write_on} == 5'b0, "R1 outputs after reset",
            {busy, done, rej, erase_on, write_on}, 0);
        readchk("R1 addr0", 10'd0, 8'hFF, 1'b0);
        readchk("R1 addr1023", 10'd1023, 8'hFF, 1'b0);
        @(negedge clk);

        // R2 refused without security check
        run("R2 no auth", 10'd5, 8'h00, 1'b0, 1'b0, 1'b0, 1, 0, 0, 0);
        readchk("R2 unchanged", 10'd5, 8'hFF, 1'b0);
        @(negedge clk);

        // R6 / R4 write only
        run("R6 write only", 10'd5, 8'hA5, 1'b0, 1'b0, 1'b1, 0, 103, 0, 103);
        readchk("R4 after write", 10'd5, 8'hA5, 1'b0);
        @(negedge clk);

        // R5 erase and write, byte is FFh during write phase
        expect_item("R5 erase and write", 0, 203, 100, 103);
        fire(10'd5, 8'h5A, 1'b0, 1'b0, 1'b1);
        repeat (100) @(negedge clk);
        readchk("R5 mid erased", 10'd5, 8'hFF, 1'b0);
        wait_idle();
        readchk("R4 after both", 10'd5, 8'h5A, 1'b0);
        @(negedge clk);

        // R6 erase only
        run("R6 erase only", 10'd5, 8'hFF, 1'b0, 1'b0, 1'b1, 0, 103, 103, 0);
        readchk("R4 after erase", 10'd5, 8'hFF, 1'b0);
        @(negedge clk);

        // R7 nothing to do
        run("R7 no change", 10'd5, 8'hFF, 1'b0, 1'b0, 1'b1, 0, 0, 0, 0);
        readchk("R7 unchanged", 10'd5, 8'hFF, 1'b0);
        @(negedge clk);

        // R9 update with lock
        run("R9 update and lock", 10'd7, 8'h3C, 1'b1, 1'b0, 1'b1, 0, 103, 0, 103);
        readchk("R9 locked byte", 10'd7, 8'h3C, 1'b1);
        @(negedge clk);

        // R3 locked byte rejects change
        run("R3 locked refuse", 10'd7, 8'hFF, 1'b0, 1'b0, 1'b1, 1, 0, 0, 0);
        readchk("R3 unchanged", 10'd7, 8'h3C, 1'b1);
        @(negedge clk);

        // R8 match mode
        run("R8 mismatch", 10'd9, 8'h12, 1'b0, 1'b1, 1'b1, 1, 0, 0, 0);
        readchk("R8 mismatch unlocked", 10'd9, 8'hFF, 1'b0);
        @(negedge clk);
        run("R8 match", 10'd9, 8'hFF, 1'b0, 1'b1, 1'b1, 0, 103, 0, 103);
        readchk("R8 match locked", 10'd9, 8'hFF, 1'b1);
        @(negedge clk);
        run("R8 already locked", 10'd9, 8'hFF, 1'b0, 1'b1, 1'b1, 0, 0, 0, 0);
        readchk("R9 lock kept", 10'd9, 8'hFF, 1'b1);
        @(negedge clk);

        // R10 ignored while busy, last busy cycle, accepted in done cycle
        expect_item("R10 first op", 0, 103, 0, 103);
        fire(10'd20, 8'h00, 1'b0, 1'b0, 1'b1);
        repeat (49) @(negedge clk);
        fire(10'd21, 8'h00, 1'b0, 1'b0, 1'b1);
        repeat (52) @(negedge clk);
        fire(10'd22, 8'h00, 1'b0, 1'b0, 1'b1);
        chk(done == 1'b1, "R10 done after last busy cycle", done, 1);
        expect_item("R10 back-to-back op", 0, 103, 0, 103);
        fire(10'd23, 8'h00, 1'b0, 1'b0, 1'b1);
        wait_idle();
        readchk("R10 mid-busy ignored", 10'd21, 8'hFF, 1'b0);
        readchk("R10 last-cycle ignored", 10'd22, 8'hFF, 1'b0);
        readchk("R10 done-cycle accepted", 10'd23, 8'h00, 1'b0);
        readchk("R10 first op result", 10'd20, 8'h00, 1'b0);
        @(negedge clk);

        // R7 no change with lock request
        run("R7 lock only", 10'd30, 8'hFF, 1'b1, 1'b0, 1'b1, 0, 0, 0, 0);
        readchk("R7 lock set at once", 10'd30, 8'hFF, 1'b1);
        @(negedge clk);

        // R2 match mode without security check
        run("R2 no auth match", 10'd40, 8'hFF, 1'b0, 1'b1, 1'b0, 1, 0, 0, 0);
        readchk("R2 match unlocked", 10'd40, 8'hFF, 1'b0);

        chk(q_tag.size() == 0, "R10 scoreboard drained", q_tag.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule